// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

An 8-bit arithmetic and logic unit that works on an accumulator byte and a second operand byte and produces the new accumulator value, a second result byte and four status flags: parity (P), signed overflow (OV), auxiliary (nibble) carry (AC) and carry/borrow (C). Single-cycle operations are purely combinational: the caller presents the operation code, both operands and the current flag values, and reads the results in the same cycle. Flags that an operation does not touch come out equal to the incoming value, so the caller can write all four back every time.

Unsigned multiply and divide of A by B run as a four-cycle sequence started by a `start` pulse. Operands are captured at the start edge, `busy` is high while the sequence runs, and `done` pulses for one cycle with the results on the same output pins used by the single-cycle operations. Operand fetch and writeback belong to the surrounding datapath.

Top module: `acc_alu`

## Requirements
- R1: Operation codes 0 (add) and 1 (add with carry) return A+B (plus c_in for code 1) on res_a; C is the carry out of bit 7, AC the carry out of bit 3, OV is set when the signed sum leaves -128..127.
- R2: Code 2 (subtract with borrow) returns A-B-c_in; C is set when a borrow leaves bit 7, AC when a borrow leaves bit 3, OV when the signed difference leaves -128..127.
- R3: Codes 3 (AND), 4 (OR), 5 (XOR), 6 (complement A) and 7 (clear A) return the logic result on res_a and leave OV, AC and C equal to ov_in, ac_in and c_in.
- R4: Codes 8 (increment) and 9 (decrement) return A+1 and A-1 modulo 256 and leave OV, AC and C unchanged.
- R5: Codes 10 (rotate left) and 12 (rotate right) rotate the eight bits of A by one position and leave OV, AC and C unchanged.
- R6: Codes 11 and 13 rotate the nine bits {C,A} left and right by one position; the bit leaving A becomes C.
- R7: Code 14 exchanges the two nibbles of A.
- R8: Code 15 returns {A[7:4],B[3:0]} on res_a and {B[7:4],A[3:0]} on res_b, flags other than P unchanged.
- R9: Code 16 (decimal adjust) adds 6 when A[3:0]>9 or AC is set, then adds 0x60 when the upper nibble of that sum is above 9 or C is set or the first step carried; C is set by any carry out and never cleared; OV and AC unchanged.
- R10: f_p equals the XOR of the eight bits of res_a for every operation, and res_b equals b_in for every single-cycle code other than 15.
- R11: Code 17 with start: done pulses on the fourth rising edge after the edge that accepts start; res_a holds the product low byte, res_b the high byte, OV is set when the product exceeds 255, C is cleared, AC keeps the value sampled at start.
- R12: Code 18 with start has the same timing; res_a holds the quotient and res_b the remainder, C and OV are cleared; for B equal to zero OV is set and C cleared.
- R13: start is ignored while busy is high, and while done is high the outputs carry the multi-cycle result regardless of op and the operand inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 5 | Operation code |
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second operand |
| c_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| start | input | 1 | Starts multiply or divide |
| res_a | output | 8 | Accumulator result |
| res_b | output | 8 | Second result byte |
| f_p | output | 1 | Parity of res_a |
| f_ov | output | 1 | Overflow flag |
| f_ac | output | 1 | Auxiliary carry flag |
| f_c | output | 1 | Carry flag |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion cycle of a multiply or divide can coincide with a single-cycle operation presented on op, because the two share the result pins. The bench switches op to an add with fresh operands and flags just before the done edge, and judges that the output in the done cycle is the product or quotient computed from the operands and AC captured at start. It also re-pulses start mid-sequence with other operands and checks that the result is unaffected.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int MD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] op,
  input  logic [7:0] a_in,
  input  logic [7:0] b_in,
  input  logic       c_in,
  input  logic       ac_in,
  input  logic       ov_in,
  input  logic       start,
  output logic [7:0] res_a,
  output logic [7:0] res_b,
  output logic       f_p,
  output logic       f_ov,
  output logic       f_ac,
  output logic       f_c,
  output logic       busy,
  output logic       done
);

  localparam int CW = (MD_CYCLES > 1) ? $clog2(MD_CYCLES) : 1;

  localparam logic [4:0] OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2;
  localparam logic [4:0] OP_AND  = 5'd3,  OP_OR   = 5'd4,  OP_XOR  = 5'd5;
  localparam logic [4:0] OP_CPL  = 5'd6,  OP_CLR  = 5'd7,  OP_INC  = 5'd8;
  localparam logic [4:0] OP_DEC  = 5'd9,  OP_RL   = 5'd10, OP_RLC  = 5'd11;
  localparam logic [4:0] OP_RR   = 5'd12, OP_RRC  = 5'd13, OP_SWAP = 5'd14;
  localparam logic [4:0] OP_XCHD = 5'd15, OP_DA   = 5'd16, OP_MUL  = 5'd17;
  localparam logic [4:0] OP_DIV  = 5'd18;

  logic [7:0] ca, cb;
  logic       cov, cac, ccy, cin;
  logic [8:0] s9, d9, da1, da2;
  logic [4:0] s4, d4;
  logic [7:0] s7, d7;
  logic       da_lo, da_hi, dc1;

  assign cin = (op == OP_ADDC) & c_in;
  assign s9  = {1'b0, a_in} + {1'b0, b_in} + {8'b0, cin};
  assign s4  = {1'b0, a_in[3:0]} + {1'b0, b_in[3:0]} + {4'b0, cin};
  assign s7  = {1'b0, a_in[6:0]} + {1'b0, b_in[6:0]} + {7'b0, cin};
  assign d9  = {1'b0, a_in} - {1'b0, b_in} - {8'b0, c_in};
  assign d4  = {1'b0, a_in[3:0]} - {1'b0, b_in[3:0]} - {4'b0, c_in};
  assign d7  = {1'b0, a_in[6:0]} - {1'b0, b_in[6:0]} - {7'b0, c_in};

  assign da_lo = (a_in[3:0] > 4'd9) | ac_in;
  assign da1   = {1'b0, a_in} + (da_lo ? 9'd6 : 9'd0);
  assign dc1   = c_in | da1[8];
  assign da_hi = (da1[7:4] > 4'd9) | dc1;
  assign da2   = {1'b0, da1[7:0]} + (da_hi ? 9'h060 : 9'd0);

  always_comb begin
    ca = a_in; cb = b_in; cov = ov_in; cac = ac_in; ccy = c_in;
    case (op)
      OP_ADD, OP_ADDC: begin ca = s9[7:0]; ccy = s9[8]; cac = s4[4]; cov = s7[7] ^ s9[8]; end
      OP_SUBB: begin ca = d9[7:0]; ccy = d9[8]; cac = d4[4]; cov = d7[7] ^ d9[8]; end
      OP_AND:  ca = a_in & b_in;
      OP_OR:   ca = a_in | b_in;
      OP_XOR:  ca = a_in ^ b_in;
      OP_CPL:  ca = ~a_in;
      OP_CLR:  ca = 8'd0;
      OP_INC:  ca = a_in + 8'd1;
      OP_DEC:  ca = a_in - 8'd1;
      OP_RL:   ca = {a_in[6:0], a_in[7]};
      OP_RR:   ca = {a_in[0], a_in[7:1]};
      OP_RLC:  begin ca = {a_in[6:0], c_in}; ccy = a_in[7]; end
      OP_RRC:  begin ca = {c_in, a_in[7:1]}; ccy = a_in[0]; end
      OP_SWAP: ca = {a_in[3:0], a_in[7:4]};
      OP_XCHD: begin ca = {a_in[7:4], b_in[3:0]}; cb = {b_in[7:4], a_in[3:0]}; end
      OP_DA:   begin ca = da2[7:0]; ccy = dc1 | da2[8]; end
      default: ;
    endcase
  end

  logic [CW-1:0] cnt;
  logic [7:0]    lat_a, lat_b, md_a, md_b;
  logic          lat_div, lat_ac, md_ov;
  logic [15:0]   prod;
  logic [7:0]    quo, rem;
  logic          is_md;

  assign is_md = (op == OP_MUL) | (op == OP_DIV);
  assign prod  = lat_a * lat_b;
  assign quo   = (lat_b == 8'd0) ? lat_a : lat_a / lat_b;
  assign rem   = (lat_b == 8'd0) ? lat_b : lat_a % lat_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0;
      lat_a <= '0; lat_b <= '0; lat_div <= 1'b0; lat_ac <= 1'b0;
      md_a <= '0; md_b <= '0; md_ov <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          md_a  <= lat_div ? quo : prod[7:0];
          md_b  <= lat_div ? rem : prod[15:8];
          md_ov <= lat_div ? (lat_b == 8'd0) : (prod[15:8] != 8'd0);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start && is_md) begin
        busy    <= 1'b1;
        cnt     <= CW'(MD_CYCLES - 1);
        lat_a   <= a_in;
        lat_b   <= b_in;
        lat_div <= (op == OP_DIV);
        lat_ac  <= ac_in;
      end
    end
  end

  assign res_a = done ? md_a   : ca;
  assign res_b = done ? md_b   : cb;
  assign f_ov  = done ? md_ov  : cov;
  assign f_ac  = done ? lat_ac : cac;
  assign f_c   = done ? 1'b0   : ccy;
  assign f_p   = ^res_a;

  p_done_follows_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);
  p_mul_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !lat_div) |-> (!f_c && (f_ov == (res_b != 8'd0))));
  p_div_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lat_div && lat_b == 8'd0) |-> (f_ov && !f_c));
  p_logic_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && op >= OP_AND && op <= OP_CLR) |-> (f_c == c_in && f_ov == ov_in && f_ac == ac_in));
  p_rotate_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && (op == OP_RL || op == OP_RR)) |-> (f_c == c_in && f_ov == ov_in && f_ac == ac_in));

endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a_in = '0, b_in = '0;
  logic c_in = 0, ac_in = 0, ov_in = 0, start = 0;
  logic [7:0] res_a, res_b;
  logic f_p, f_ov, f_ac, f_c, busy, done;
  int tests = 0, fails = 0;

  acc_alu dut (.clk(clk), .rst_n(rst_n), .op(op), .a_in(a_in), .b_in(b_in),
    .c_in(c_in), .ac_in(ac_in), .ov_in(ov_in), .start(start), .res_a(res_a),
    .res_b(res_b), .f_p(f_p), .f_ov(f_ov), .f_ac(f_ac), .f_c(f_c),
    .busy(busy), .done(done));

  always #5 clk = ~clk;

  task automatic chk(input string req, input bit ok, input logic [19:0] act, input logic [19:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sx(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic string rq(input int o);
    case (o)
      0, 1: return "R1";  2: return "R2";  3, 4, 5, 6, 7: return "R3";
      8, 9: return "R4";  10, 12: return "R5";  11, 13: return "R6";
      14: return "R7";  15: return "R8";  default: return "R9";
    endcase
  endfunction

  initial begin
    #1_900_000;
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    #2;
    chk("R11 reset", busy == 0 && done == 0, {18'd0, busy, done}, 20'd0);

    for (int o = 0; o <= 16; o++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 16; bi++)
          for (int fl = 0; fl < 4; fl++) begin
            int b, c, ac, ov, ea, eb, ep, eov, eac, ec, s, ss, t;
            b = bi * 17 ^ (a & 8'h0F); c = fl & 1; ac = (fl >> 1) & 1; ov = (a ^ bi) & 1;
            ea = a; eb = b; eov = ov; eac = ac; ec = c;
            case (o)
              0, 1: begin
                int ci; ci = (o == 1) ? c : 0;
                s = a + b + ci; ea = s & 255; ec = int'(s > 255);
                eac = int'((a % 16) + (b % 16) + ci > 15);
                ss = sx(a) + sx(b) + ci; eov = int'(ss > 127 || ss < -128);
              end
              2: begin
                s = a - b - c; ea = s & 255; ec = int'(s < 0);
                eac = int'((a % 16) - (b % 16) - c < 0);
                ss = sx(a) - sx(b) - c; eov = int'(ss > 127 || ss < -128);
              end
              3: ea = a & b;  4: ea = a | b;  5: ea = a ^ b;
              6: ea = 255 - a; 7: ea = 0;
              8: ea = (a + 1) & 255;  9: ea = (a + 255) & 255;
              10: ea = ((a << 1) & 255) | (a >> 7);
              12: ea = (a >> 1) | ((a & 1) << 7);
              11: begin ea = ((a << 1) & 255) | c; ec = a >> 7; end
              13: begin ea = (a >> 1) | (c << 7); ec = a & 1; end
              14: ea = ((a & 15) << 4) | (a >> 4);
              15: begin ea = (a & 8'hF0) | (b & 15); eb = (b & 8'hF0) | (a & 15); end
              default: begin
                t = a;
                if ((a & 15) > 9 || ac == 1) t = t + 6;
                if (t > 255) ec = 1;
                t = t & 255;
                if ((t >> 4) > 9 || ec == 1) t = t + 8'h60;
                if (t > 255) ec = 1;
                ea = t & 255;
              end
            endcase
            ep = ^ea[7:0];
            op = o[4:0]; a_in = a[7:0]; b_in = b[7:0];
            c_in = c[0]; ac_in = ac[0]; ov_in = ov[0];
            #1;
            begin
              logic [19:0] act, exp;
              act = {res_a, res_b, f_p, f_ov, f_ac, f_c};
              exp = {ea[7:0], eb[7:0], ep[0], eov[0], eac[0], ec[0]};
              if (act[19:12] != exp[19:12] || act[2:0] != exp[2:0])
                chk(rq(o), 0, act, exp);
              else if (act[11:4] != exp[11:4] || act[3] != exp[3])
                chk("R10", 0, act, exp);
              else
                chk(rq(o), 1, act, exp);
            end
          end

    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 16; bi++) begin
          int b, ea, eb, eov, acs;
          string r;
          b = (bi == 1) ? 1 : bi * 17;
          acs = (a >> 1) & 1;
          r = d ? "R12" : "R11";
          if (d == 1) begin
            if (b == 0) begin ea = 0; eb = 0; eov = 1; end
            else begin ea = a / b; eb = a % b; eov = 0; end
          end else begin
            ea = (a * b) & 255; eb = (a * b) >> 8; eov = int'(a * b > 255);
          end
          @(negedge clk);
          op = d ? 5'd18 : 5'd17; a_in = a[7:0]; b_in = b[7:0];
          ac_in = acs[0]; c_in = 1'b1; start = 1'b1;
          for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (k == 2 && (a % 8) == 0) begin
              start = 1'b1; op = d ? 5'd17 : 5'd18; a_in = ~a[7:0]; b_in = 8'd3;
            end
            if (k == 4) begin
              op = 5'd0; a_in = 8'h5A; b_in = 8'hC3; ac_in = ~acs[0]; c_in = 1'b1; ov_in = 1'b0;
            end
            if (k < 5 && done)
              chk({r, " early done"}, 0, {19'd0, done}, 20'd0);
          end
          if (!done) chk({r, " done timing"}, 0, 20'd0, 20'd1);
          else if (d == 1 && b == 0)
            chk("R12 div by zero", f_ov && !f_c && f_ac == acs[0] && f_p == ^res_a,
                {res_a, res_b, f_p, f_ov, f_ac, f_c}, {16'd0, ^res_a, 1'b1, acs[0], 1'b0});
          else
            chk({r, " R13 result"}, {res_a, res_b, f_p, f_ov, f_ac, f_c} ==
                {ea[7:0], eb[7:0], ^ea[7:0], eov[0], acs[0], 1'b0},
                {res_a, res_b, f_p, f_ov, f_ac, f_c},
                {ea[7:0], eb[7:0], ^ea[7:0], eov[0], acs[0], 1'b0});
          @(negedge clk);
          if (done || busy) chk("R13 pulse width", 0, {18'd0, busy, done}, 20'd0);
        end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule